// File: doc/BRIEF.md
# Serial I/Q Frame Output Port

This block sends complex samples out of one serial data pin. A sample is an in-phase word and a quadrature word. The in-phase word goes first and the quadrature word follows, each most significant bit first. A sample enters through a one-cycle valid strobe and waits in a one-deep holding register. A data-ready flag tells the receiver that a sample is waiting. Each frame is marked by a frame-sync output and a frame-end output. The frame-end of one port can drive the frame-sync input of the next port, so several ports can share one serial line in a time-division chain.

The port runs in one of two roles. As master, it derives its own serial clock from the system clock through a small programmable divider. It starts a frame on the first serial clock rising edge after a sample becomes ready. As slave, it takes the serial clock and frame sync from outside. Both inputs are synchronised into the system clock domain, and the frame starts on the serial edge after the sync is seen. The role is captured while reset is held. Three frame-sync placements and three word widths can be selected.

Top module: `iq_serial_port`

## Requirements
- R1: A frame shows one idle lead period, then the W most significant bits of the in-phase word, then the W most significant bits of the quadrature word, MSB first. One bit is shown per serial period, so the last bit is quadrature bit MAX_W-W.
- R2: The width code on `wsel` selects W: 0 gives MAX_W (24), 1 gives two thirds of MAX_W (16), 2 gives half of MAX_W (12), and 3 is treated as MAX_W. W is taken when the frame starts.
- R3: With `sync_mode` 0, a master raises `fsync_out` for exactly the lead period, the one before the first in-phase bit. Code 3 behaves like code 0.
- R4: With `sync_mode` 1, a master holds `fsync_out` high from the lead period through the last quadrature bit.
- R5: With `sync_mode` 2, a master raises `fsync_out` in the lead period and again in the period of the last in-phase bit, the one just before the first quadrature bit. It is low otherwise.
- R6: In every mode, `fend` is high exactly during the period of the last quadrature bit.
- R7: A slave samples `fsync_in` on a rising edge of `sclk_in` and shows the first data bit after the next rising edge. A sync seen while a frame is in progress is ignored. A sync seen with no sample ready is also ignored.
- R8: A master's `sclk_out` has a period of `sdiv`+1 system clocks, with code 0 treated as 1. Its rising edge coincides with the update of `sdo`, `fsync_out` and `fend`. These outputs change only on serial rising edges.
- R9: `data_ready` rises in the cycle after a sample strobe. It falls in the cycle after the lead period begins. A sample that arrives during a frame is held and sent in the next frame. A newer sample replaces one that has not yet been sent.
- R10: The role is latched from `master_sel` while `rst` is high, and later changes are ignored. A slave drives `sclk_out` and `fsync_out` low.
- R11: `sdo`, `fend`, `fsync_out` and `data_ready` are low in reset. Whenever no frame is being shown, `sdo`, `fend` and `fsync_out` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; role latched while high |
| master_sel | input | 1 | 1 selects master role, 0 selects slave role |
| sdiv | input | DIV_W | Serial clock divide code, period = sdiv+1 |
| wsel | input | 2 | Word width code |
| sync_mode | input | 2 | Frame-sync placement code |
| smp_valid | input | 1 | One-cycle strobe for a new sample |
| smp_i | input | MAX_W | In-phase word of the new sample |
| smp_q | input | MAX_W | Quadrature word of the new sample |
| sclk_in | input | 1 | External serial clock (slave) |
| fsync_in | input | 1 | External frame sync (slave) |
| sclk_out | output | 1 | Generated serial clock (master) |
| fsync_out | output | 1 | Generated frame sync (master) |
| sdo | output | 1 | Serial data |
| fend | output | 1 | Frame end marker |
| data_ready | output | 1 | A sample is waiting to be sent |

## Verification
The hardest case to reach is a slave that already has a sample waiting while a frame is still being shifted, and that sees a sync pulse in the middle of that frame. Only in that state can a wrong restart corrupt data. The bench gets there in slave mode. It strobes a second sample during an active frame and then pulses `fsync_in` a few periods into the same frame. It then checks that the frame finishes unchanged and that `data_ready` is still high afterwards. Only then does it send the held sample with a fresh sync. An earlier pair of strobes before any sync, and a sync with an empty buffer, cover the replacement rule and the empty-buffer rule.

// File: rtl/iqs_pkg.sv
package iqs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LEAD = 2'd1,
        ST_DATA = 2'd2
    } fr_state_e;

    typedef enum logic [1:0] {
        SM_PULSE = 2'd0,
        SM_HOLD  = 2'd1,
        SM_DUAL  = 2'd2
    } sync_mode_e;

endpackage

// File: rtl/iqs_clkgen.sv
module iqs_clkgen #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             is_master,
    input  logic [DIV_W-1:0] sdiv,
    input  logic             sclk_in,
    input  logic             fsync_in,
    output logic             tick,
    output logic             fs_smp,
    output logic             sclk_out
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sclk;
        logic [2:0]       ck;
        logic [1:0]       fs;
    } ck_t;

    ck_t q, d;

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W:0]   high_len;
    logic             m_tick;
    logic             s_tick;

    always_comb begin
        div_eff  = (sdiv == '0) ? DIV_W'(1) : sdiv;
        high_len = ({1'b0, div_eff} + (DIV_W+1)'(1)) >> 1;
        m_tick   = is_master && (q.cnt >= div_eff);
        s_tick   = !is_master && q.ck[1] && !q.ck[2];

        d    = q;
        d.ck = {q.ck[1:0], sclk_in};
        d.fs = {q.fs[0], fsync_in};
        if (is_master) begin
            d.cnt  = m_tick ? '0 : q.cnt + DIV_W'(1);
            d.sclk = ({1'b0, d.cnt} < high_len);
        end else begin
            d.cnt  = '0;
            d.sclk = 1'b0;
        end

        tick     = m_tick || s_tick;
        fs_smp   = q.fs[1];
        sclk_out = q.sclk;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R8: a master serial tick always produces a rising serial clock edge
    a_r8_rise_on_tick: assert property (@(posedge clk) disable iff (rst)
        (is_master && m_tick) |=> sclk_out);

    // R10: slave never drives a clock
    a_r10_slave_clk_low: assert property (@(posedge clk) disable iff (rst)
        (!is_master && !$past(is_master)) |-> !sclk_out);

endmodule

// File: rtl/iqs_buffer.sv
module iqs_buffer #(
    parameter int MAX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [MAX_W-1:0] i_in,
    input  logic [MAX_W-1:0] q_in,
    input  logic             take,
    output logic             ready,
    output logic [MAX_W-1:0] i_out,
    output logic [MAX_W-1:0] q_out
);

    typedef struct packed {
        logic             rdy;
        logic [MAX_W-1:0] iw;
        logic [MAX_W-1:0] qw;
    } buf_t;

    buf_t q, d;

    always_comb begin
        d = q;
        if (take) d.rdy = 1'b0;
        if (wr) begin
            d.rdy = 1'b1;
            d.iw  = i_in;
            d.qw  = q_in;
        end
        ready = q.rdy;
        i_out = q.iw;
        q_out = q.qw;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R9: taking the held sample empties the buffer unless a new one lands
    a_r9_take_clears: assert property (@(posedge clk) disable iff (rst)
        (take && !wr) |=> !ready);

    // R9: a strobe always leaves a sample waiting
    a_r9_strobe_sets: assert property (@(posedge clk) disable iff (rst)
        wr |=> (ready && i_out == $past(i_in) && q_out == $past(q_in)));

endmodule

// File: rtl/iqs_shifter.sv
module iqs_shifter
    import iqs_pkg::*;
#(
    parameter int MAX_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             is_master,
    input  logic             fs_smp,
    input  logic [1:0]       wcode,
    input  logic [1:0]       mode,
    input  logic             ready,
    input  logic [MAX_W-1:0] i_buf,
    input  logic [MAX_W-1:0] q_buf,
    output logic             take,
    output logic             sdo,
    output logic             fsync_out,
    output logic             fend
);

    localparam int CNT_W = $clog2(2*MAX_W + 1);
    localparam int IDX_W = $clog2(MAX_W);
    localparam int W_MID = (MAX_W * 2) / 3;
    localparam int W_LOW = MAX_W / 2;

    typedef struct packed {
        fr_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] wd;
        logic [MAX_W-1:0] iw;
        logic [MAX_W-1:0] qw;
        logic             sdo;
        logic             fs;
        logic             fe;
    } sh_t;

    sh_t q, d;

    logic [CNT_W-1:0] wlen;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] pos;
    logic [IDX_W-1:0] bsel;
    logic             in_q;
    logic             want;
    logic             can_start;

    always_comb begin
        d    = q;
        take = 1'b0;

        case (wcode)
            2'd1:    wlen = CNT_W'(W_MID);
            2'd2:    wlen = CNT_W'(W_LOW);
            default: wlen = CNT_W'(MAX_W);
        endcase

        last      = q.wd << 1;
        want      = is_master ? ready : (ready && fs_smp);
        can_start = (q.st == ST_IDLE) || ((q.st == ST_DATA) && (q.cnt == last));
        idx       = (q.st == ST_LEAD) ? '0 : q.cnt;
        in_q      = (idx >= q.wd);
        pos       = in_q ? (idx - q.wd) : idx;
        bsel      = IDX_W'(MAX_W - 1) - IDX_W'(pos);

        if (tick) begin
            if (can_start) begin
                d.st  = ST_IDLE;
                d.sdo = 1'b0;
                d.fe  = 1'b0;
                d.fs  = 1'b0;
                d.cnt = '0;
                if (want) begin
                    take  = 1'b1;
                    d.st  = ST_LEAD;
                    d.iw  = i_buf;
                    d.qw  = q_buf;
                    d.wd  = wlen;
                    d.fs  = is_master;
                end
            end else begin
                d.st  = ST_DATA;
                d.cnt = idx + CNT_W'(1);
                d.sdo = in_q ? q.qw[bsel] : q.iw[bsel];
                d.fe  = (idx == last - CNT_W'(1));
                d.fs  = is_master &&
                        ((mode == SM_HOLD) ||
                         ((mode == SM_DUAL) && (idx == q.wd - CNT_W'(1))));
            end
        end

        sdo       = q.sdo;
        fsync_out = q.fs;
        fend      = q.fe;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // R11: nothing is driven while no frame is shown
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_IDLE) |-> (!q.sdo && !q.fe && !q.fs));

    // R6: frame end only alongside the final bit
    a_r6_fend_last_bit: assert property (@(posedge clk) disable iff (rst)
        q.fe |-> ((q.st == ST_DATA) && (q.cnt == last)));

    // R3: the lead period carries the sync in master role and no data
    a_r3_lead_sync: assert property (@(posedge clk) disable iff (rst)
        (q.st == ST_LEAD) |-> ((q.fs == is_master) && !q.sdo && !q.fe));

    // R7: after the lead period the first data bit follows on the next tick
    a_r7_lead_then_data: assert property (@(posedge clk) disable iff (rst)
        (tick && q.st == ST_LEAD) |=> ((q.st == ST_DATA) && (q.cnt == CNT_W'(1))));

    // R8: serial outputs only move on serial rising edges
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(q.sdo) && $stable(q.fs) && $stable(q.fe)));

endmodule

// File: rtl/iq_serial_port.sv
module iq_serial_port #(
    parameter int MAX_W = 24,
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             master_sel,
    input  logic [DIV_W-1:0] sdiv,
    input  logic [1:0]       wsel,
    input  logic [1:0]       sync_mode,
    input  logic             smp_valid,
    input  logic [MAX_W-1:0] smp_i,
    input  logic [MAX_W-1:0] smp_q,
    input  logic             sclk_in,
    input  logic             fsync_in,
    output logic             sclk_out,
    output logic             fsync_out,
    output logic             sdo,
    output logic             fend,
    output logic             data_ready
);

    logic             role_q, role_d;
    logic             tick;
    logic             fs_smp;
    logic             take;
    logic [MAX_W-1:0] i_buf;
    logic [MAX_W-1:0] q_buf;

    always_comb role_d = role_q;

    always_ff @(posedge clk) begin
        if (rst) role_q <= master_sel;
        else     role_q <= role_d;
    end

    iqs_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk      (clk),
        .rst      (rst),
        .is_master(role_q),
        .sdiv     (sdiv),
        .sclk_in  (sclk_in),
        .fsync_in (fsync_in),
        .tick     (tick),
        .fs_smp   (fs_smp),
        .sclk_out (sclk_out)
    );

    iqs_buffer #(.MAX_W(MAX_W)) u_buf (
        .clk  (clk),
        .rst  (rst),
        .wr   (smp_valid),
        .i_in (smp_i),
        .q_in (smp_q),
        .take (take),
        .ready(data_ready),
        .i_out(i_buf),
        .q_out(q_buf)
    );

    iqs_shifter #(.MAX_W(MAX_W)) u_sh (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .is_master(role_q),
        .fs_smp   (fs_smp),
        .wcode    (wsel),
        .mode     (sync_mode),
        .ready    (data_ready),
        .i_buf    (i_buf),
        .q_buf    (q_buf),
        .take     (take),
        .sdo      (sdo),
        .fsync_out(fsync_out),
        .fend     (fend)
    );

    // R10: the latched role never moves outside reset
    a_r10_role_hold: assert property (@(posedge clk) disable iff (rst)
        $stable(role_q));

endmodule

// File: tb/iq_serial_port_test.sv
module iq_serial_port_test;

    localparam int MW = 24;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          master_sel = 1'b1;
    logic [1:0]    sdiv = 2'd1;
    logic [1:0]    wsel = 2'd0;
    logic [1:0]    sync_mode = 2'd0;
    logic          smp_valid = 1'b0;
    logic [MW-1:0] smp_i = '0;
    logic [MW-1:0] smp_q = '0;
    logic          sclk_in = 1'b0;
    logic          fsync_in = 1'b0;
    logic          sclk_out, fsync_out, sdo, fend, data_ready;

    always #5 clk = ~clk;

    iq_serial_port uut (
        .clk(clk), .rst(rst), .master_sel(master_sel), .sdiv(sdiv),
        .wsel(wsel), .sync_mode(sync_mode), .smp_valid(smp_valid),
        .smp_i(smp_i), .smp_q(smp_q), .sclk_in(sclk_in), .fsync_in(fsync_in),
        .sclk_out(sclk_out), .fsync_out(fsync_out), .sdo(sdo), .fend(fend),
        .data_ready(data_ready)
    );

    typedef struct {
        logic [MW-1:0] i;
        logic [MW-1:0] q;
        int            w;
        int            mode;
    } frm_t;

    frm_t exp_q[$];
    frm_t cur;
    int   total = 0;
    int   bad = 0;
    bit   finished = 0;
    bit   is_master_tb = 0;
    bit   mon_on = 0;
    int   mon_idx = 0;
    logic prev_sclk = 1'b0;
    int   cyc = 0;
    int   last_rise = 0;
    int   last_period = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int wcode2w(input logic [1:0] c);
        case (c)
            2'd1:    return 16;
            2'd2:    return 12;
            default: return 24;
        endcase
    endfunction

    // monitor: judge one serial period against the scoreboard
    task automatic on_period(input logic fs, input logic d, input logic fe, input bit hint);
        bit   startf;
        logic e;
        bit   efs;
        if (!mon_on) begin
            startf = is_master_tb ? fs : hint;
            if (startf && exp_q.size() > 0) begin
                cur     = exp_q.pop_front();
                mon_on  = 1;
                mon_idx = 0;
                chk(fs == is_master_tb, "R3 lead period sync", fs, is_master_tb);
                chk(d == 1'b0 && fe == 1'b0, "R1 lead period quiet", {d, fe}, 0);
            end else begin
                chk(d == 1'b0, "R11 idle sdo", d, 0);
                chk(fe == 1'b0, "R11 idle fend", fe, 0);
                chk(fs == 1'b0, "R11 idle fsync", fs, 0);
            end
        end else begin
            e = (mon_idx < cur.w) ? cur.i[MW-1-mon_idx] : cur.q[MW-1-(mon_idx-cur.w)];
            chk(d == e, (cur.w == 24) ? "R1 data bit" : "R2 narrow data bit", d, e);
            chk(fe == (mon_idx == 2*cur.w-1), "R6 frame end", fe, mon_idx == 2*cur.w-1);
            efs = is_master_tb && (cur.mode == 1 || (cur.mode == 2 && mon_idx == cur.w-1));
            chk(fs == efs, (cur.mode == 1) ? "R4 held sync" :
                           (cur.mode == 2) ? "R5 dual sync" : "R3 single sync", fs, efs);
            mon_idx++;
            if (mon_idx == 2*cur.w) mon_on = 0;
        end
    endtask

    // master-side monitor: one record per generated serial rising edge
    always @(negedge clk) begin
        cyc++;
        if (is_master_tb && !rst) begin
            if (sclk_out && !prev_sclk) begin
                last_period = cyc - last_rise;
                last_rise   = cyc;
                on_period(fsync_out, sdo, fend, 1'b0);
            end
            prev_sclk = sclk_out;
        end else begin
            prev_sclk = 1'b0;
        end
    end

    // driver: push the expected frame, then strobe the sample in
    task automatic push(input logic [MW-1:0] iv, input logic [MW-1:0] qv, input bit replace);
        frm_t f;
        f.i    = iv;
        f.q    = qv;
        f.w    = wcode2w(wsel);
        f.mode = (sync_mode == 2'd3) ? 0 : int'(sync_mode);
        if (replace && exp_q.size() > 0) exp_q[exp_q.size()-1] = f;
        else exp_q.push_back(f);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_i     = iv;
        smp_q     = qv;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int n = 0;
        while ((exp_q.size() > 0 || mon_on) && n < limit) begin
            @(negedge clk);
            n++;
        end
        chk(n < limit, "R9 queued frames all sent", n, limit);
        repeat (6) @(negedge clk);
    endtask

    task automatic do_reset(input bit m);
        is_master_tb = 0;
        mon_on       = 0;
        exp_q.delete();
        @(negedge clk);
        rst        = 1'b1;
        master_sel = m;
        repeat (4) @(negedge clk);
        chk(sdo == 0 && fend == 0 && fsync_out == 0 && data_ready == 0,
            "R11 reset state", {sdo, fend, fsync_out, data_ready}, 0);
        rst          = 1'b0;
        is_master_tb = m;
    endtask

    task automatic slave_period(input bit fsv);
        @(negedge clk);
        fsync_in = fsv;
        sclk_in  = 1'b1;
        repeat (8) @(negedge clk);
        sclk_in = 1'b0;
        repeat (7) @(negedge clk);
        on_period(fsync_out, sdo, fend, fsv);
    endtask

    task automatic slave_idle(input int n);
        for (int k = 0; k < n; k++) slave_period(1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // ---------------- master role ----------------
        do_reset(1'b1);
        @(negedge clk);
        chk(data_ready == 0, "R9 empty after reset", data_ready, 0);

        sdiv = 2'd1; wsel = 2'd0; sync_mode = 2'd0;
        push(24'hA5C3F1, 24'h3C96E8, 1'b0);
        chk(data_ready == 1, "R9 ready after strobe", data_ready, 1);
        wait_done(2000);
        chk(data_ready == 0, "R9 ready cleared after send", data_ready, 0);

        // serial clock period for each divide code (R8)
        for (int dv = 0; dv < 4; dv++) begin
            sdiv = dv[1:0];
            repeat (20) @(negedge clk);
            chk(last_period == ((dv == 0) ? 2 : dv + 1), "R8 serial clock period",
                last_period, (dv == 0) ? 2 : dv + 1);
        end

        sdiv = 2'd2; wsel = 2'd1; sync_mode = 2'd1;
        push(24'h5E2B7D, 24'hC01F4A, 1'b0);
        wait_done(4000);

        wsel = 2'd2; sync_mode = 2'd2;
        push(24'h9B1234, 24'h7E8D55, 1'b0);
        wait_done(4000);

        sdiv = 2'd3; wsel = 2'd3; sync_mode = 2'd3;
        push(24'h0F0F0F, 24'hF00FF1, 1'b0);
        wait_done(4000);

        // sample arriving mid-frame is held for the next frame (R9)
        sdiv = 2'd1; wsel = 2'd0; sync_mode = 2'd2;
        push(24'h123456, 24'h89ABCD, 1'b0);
        repeat (12) @(negedge clk);
        push(24'hFEDCBA, 24'h765432, 1'b0);
        chk(data_ready == 1, "R9 held during frame", data_ready, 1);
        wait_done(4000);

        // later role input changes are ignored (R10)
        do_reset(1'b1);
        master_sel = 1'b0;
        sdiv = 2'd1; wsel = 2'd1; sync_mode = 2'd0;
        push(24'hB4B4B4, 24'h4B4B4B, 1'b0);
        wait_done(2000);
        chk(last_period == 2, "R10 master role kept", last_period, 2);

        // ---------------- slave role ----------------
        do_reset(1'b0);
        master_sel = 1'b1;
        begin
            int hi = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (sclk_out || fsync_out) hi++;
            end
            chk(hi == 0, "R10 slave drives no clock or sync", hi, 0);
        end
        wsel = 2'd0; sync_mode = 2'd2;
        slave_idle(3);

        // sync with nothing waiting is ignored (R7)
        slave_period(1'b1);
        slave_idle(2);
        chk(sdo == 0 && data_ready == 0, "R7 sync with empty buffer ignored",
            {sdo, data_ready}, 0);

        // newer sample replaces unsent one (R9)
        push(24'h111111, 24'h222222, 1'b0);
        push(24'hC3A5E7, 24'h1D2E3F, 1'b1);
        chk(data_ready == 1, "R9 ready in slave", data_ready, 1);
        slave_period(1'b1);
        chk(data_ready == 0, "R9 ready drops at lead", data_ready, 0);
        slave_idle(4);
        // new sample arrives, then a sync mid-frame that must be ignored (R7)
        push(24'h6A6A6A, 24'h959595, 1'b0);
        slave_period(1'b1);
        slave_idle(2*24 - 5);
        slave_idle(3);
        chk(data_ready == 1, "R7 mid-frame sync ignored", data_ready, 1);
        chk(mon_on == 0 && exp_q.size() == 1, "R7 only one frame sent",
            exp_q.size(), 1);
        slave_period(1'b1);
        slave_idle(2*24 + 2);
        chk(exp_q.size() == 0 && mon_on == 0, "R7 held frame sent after sync",
            exp_q.size(), 0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule